// File: doc/BRIEF.md
# Block-Transfer DMA Engine

This block moves a block of words between an I/O peripheral and memory so that the processor does not have to. Software uses a small word-wide register port. It programs a first memory address and a word count. It then writes a command word that holds a start bit and a direction bit. Once the block runs, the CPU is free.

While a block is running, the engine holds a request to the shared-bus arbiter. It touches memory only in cycles where the grant is present. It moves one word in every cycle where the grant is high and the peripheral reports ready. The same cycle carries the peripheral strobe and the memory access. Memory reads are asynchronous, so read data is valid in the cycle of the read. After the final word the engine drops its request and raises an interrupt. The interrupt stays high until software clears it. A zero-length command completes at once and never requests the bus.

Top module: `blk_dma`

## Requirements
- R1: After reset `bus_req`, `irq`, `mem_wr`, `mem_rd` and `per_stb` are low, and every register reads back zero.
- R2: Register select 0 holds the start address and 1 holds the word count; both read back as written. Select 2 is the command: bit 0 starts, bit 1 picks the direction (0 = peripheral to memory, 1 = memory to peripheral). Select 3 is status: bit 0 busy, bit 1 done/interrupt.
- R3: `mem_wr` or `mem_rd` is asserted only while both `bus_req` and `bus_gnt` are high. `bus_req` rises at the clock edge that accepts a start with a nonzero count.
- R4: In peripheral-to-memory mode, each word pulses `per_stb` and `mem_wr` in the same cycle. The written data is `per_rdata`, and word k goes to start address + k.
- R5: In memory-to-peripheral mode, each word pulses `per_stb` and `mem_rd` in the same cycle. `per_wdata` carries the word read from start address + k.
- R6: No word moves (no `per_stb`) in a cycle where `bus_gnt` or `per_rdy` is low.
- R7: At the edge that ends the last word's cycle, `bus_req` falls and `irq` rises.
- R8: A start with a count of zero sets `irq` at the accepting edge and never raises `bus_req`.
- R9: `irq` stays high until a status write with bit 1 set. A status write with bit 1 clear leaves it unchanged.
- R10: While busy, writes to address, count and command are ignored, and a start bit written then does not begin a new block.
- R11: If a status clear arrives in the same cycle as a block completion, the completion wins and `irq` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational) |
| irq | output | 1 | Completion interrupt |
| bus_req | output | 1 | Request to the bus arbiter |
| bus_gnt | input | 1 | Grant from the bus arbiter |
| mem_addr | output | AW | Memory word address (zero without grant) |
| mem_wr | output | 1 | Memory write strobe |
| mem_rd | output | 1 | Memory read strobe |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid in the read cycle |
| per_rdy | input | 1 | Peripheral ready |
| per_stb | output | 1 | Peripheral word strobe |
| per_wdata | output | DW | Data to the peripheral |
| per_rdata | input | DW | Data from the peripheral |

## Verification
Two events can meet in one cycle: the final word of a block sets the interrupt, and a software write-one-to-clear of status removes it. The bench leaves an earlier interrupt pending and starts a one-word block with the grant held low. It then raises grant and ready in the very cycle that it issues the status clear. It judges the result by `irq` still being high and status showing idle in the following cycle.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_LEN  = 2'd1;
  localparam logic [1:0] SEL_CMD  = 2'd2;
  localparam logic [1:0] SEL_STAT = 2'd3;
  localparam int CMD_GO_BIT   = 0;
  localparam int CMD_DIR_BIT  = 1;
  localparam int STAT_BSY_BIT = 0;
  localparam int STAT_DN_BIT  = 1;

  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} eng_state_t;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_sel,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          busy,
  input  logic          done_set,
  output logic [AW-1:0] cfg_addr,
  output logic [CW-1:0] cfg_len,
  output logic          start_go,
  output logic          start_dir,
  output logic          irq
);
  logic [AW-1:0] addr_q, addr_d;
  logic [CW-1:0] len_q, len_d;
  logic          dir_q, dir_d;
  logic          irq_q, irq_d;
  logic          cfg_we, clr;

  always_comb begin
    cfg_we    = reg_we && !busy;
    clr       = reg_we && (reg_sel == SEL_STAT) && reg_wdata[STAT_DN_BIT];
    addr_d    = (cfg_we && reg_sel == SEL_ADDR) ? reg_wdata[AW-1:0] : addr_q;
    len_d     = (cfg_we && reg_sel == SEL_LEN)  ? reg_wdata[CW-1:0] : len_q;
    dir_d     = (cfg_we && reg_sel == SEL_CMD)  ? reg_wdata[CMD_DIR_BIT] : dir_q;
    start_go  = cfg_we && (reg_sel == SEL_CMD) && reg_wdata[CMD_GO_BIT];
    start_dir = reg_wdata[CMD_DIR_BIT];
    irq_d     = done_set || (irq_q && !clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      len_q  <= '0;
      dir_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      addr_q <= addr_d;
      len_q  <= len_d;
      dir_q  <= dir_d;
      irq_q  <= irq_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      SEL_ADDR: reg_rdata[AW-1:0] = addr_q;
      SEL_LEN:  reg_rdata[CW-1:0] = len_q;
      SEL_CMD:  reg_rdata[CMD_DIR_BIT] = dir_q;
      default: begin
        reg_rdata[STAT_BSY_BIT] = busy;
        reg_rdata[STAT_DN_BIT]  = irq_q;
      end
    endcase
  end

  assign cfg_addr = addr_q;
  assign cfg_len  = len_q;
  assign irq      = irq_q;

  assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(addr_q) && $stable(len_q) && $stable(dir_q)));
  assert_irq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !clr) |=> irq_q);
  assert_done_beats_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_set |=> irq_q);
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_go,
  input  logic          start_dir,
  input  logic [AW-1:0] cfg_addr,
  input  logic [CW-1:0] cfg_len,
  output logic          busy,
  output logic          done_set,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic [AW-1:0] mem_addr,
  output logic          mem_wr,
  output logic          mem_rd,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          per_rdy,
  output logic          per_stb,
  output logic [DW-1:0] per_wdata,
  input  logic [DW-1:0] per_rdata
);
  localparam logic [CW-1:0] ONE_WORD = CW'(1);

  eng_state_t    st_q, st_d;
  logic [AW-1:0] cur_q, cur_d;
  logic [CW-1:0] rem_q, rem_d;
  logic          dir_q, dir_d;
  logic          go, last;

  always_comb begin
    st_d     = st_q;
    cur_d    = cur_q;
    rem_d    = rem_q;
    dir_d    = dir_q;
    done_set = 1'b0;
    go       = (st_q == ST_RUN) && bus_gnt && per_rdy;
    last     = (rem_q == ONE_WORD);
    if (st_q == ST_IDLE) begin
      if (start_go) begin
        if (cfg_len == '0) begin
          done_set = 1'b1;
        end else begin
          st_d  = ST_RUN;
          cur_d = cfg_addr;
          rem_d = cfg_len;
          dir_d = start_dir;
        end
      end
    end else if (go) begin
      cur_d = cur_q + AW'(1);
      rem_d = rem_q - ONE_WORD;
      if (last) begin
        st_d     = ST_IDLE;
        done_set = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cur_q <= '0;
      rem_q <= '0;
      dir_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cur_q <= cur_d;
      rem_q <= rem_d;
      dir_q <= dir_d;
    end
  end

  always_comb begin
    busy      = (st_q == ST_RUN);
    bus_req   = busy;
    mem_addr  = (busy && bus_gnt) ? cur_q : '0;
    per_stb   = go;
    mem_wr    = go && !dir_q;
    mem_rd    = go && dir_q;
    mem_wdata = per_rdata;
    per_wdata = mem_rdata;
  end

  assert_grant_before_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr || mem_rd) |-> (bus_req && bus_gnt));
  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (per_stb && !last) |=> (cur_q == $past(cur_q) + AW'(1)));
  assert_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_gnt && per_rdy) |-> !per_stb);
  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (per_stb && last) |=> !bus_req);
  assert_zero_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start_go && cfg_len == '0) |=> !bus_req);
endmodule

// File: rtl/blk_dma.sv
module blk_dma #(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_sel,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic [AW-1:0] mem_addr,
  output logic          mem_wr,
  output logic          mem_rd,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          per_rdy,
  output logic          per_stb,
  output logic [DW-1:0] per_wdata,
  input  logic [DW-1:0] per_rdata
);
  logic          busy, done_set, start_go, start_dir;
  logic [AW-1:0] cfg_addr;
  logic [CW-1:0] cfg_len;

  dma_regs #(.AW(AW), .CW(CW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
    .done_set(done_set), .cfg_addr(cfg_addr), .cfg_len(cfg_len),
    .start_go(start_go), .start_dir(start_dir), .irq(irq)
  );

  dma_engine #(.AW(AW), .CW(CW), .DW(DW)) u_eng (
    .clk(clk), .rst_n(rst_n), .start_go(start_go), .start_dir(start_dir),
    .cfg_addr(cfg_addr), .cfg_len(cfg_len), .busy(busy), .done_set(done_set),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_addr(mem_addr),
    .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .per_rdy(per_rdy), .per_stb(per_stb),
    .per_wdata(per_wdata), .per_rdata(per_rdata)
  );
endmodule

// File: tb/blk_dma_tb.sv
module blk_dma_tb;
  localparam int CLK_NS = 10;
  localparam int AW = 16;
  localparam int CW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_we;
  logic [1:0]    reg_sel;
  logic [DW-1:0] reg_wdata, reg_rdata;
  logic          irq, bus_req, bus_gnt;
  logic [AW-1:0] mem_addr;
  logic          mem_wr, mem_rd, per_rdy, per_stb;
  logic [DW-1:0] mem_wdata, mem_rdata, per_wdata, per_rdata;

  int checks = 0;
  int errors = 0;

  logic [DW-1:0] mem [16];
  logic [DW-1:0] sink [16];
  int src_idx = 0;
  int stb_cnt = 0;
  int bad_access = 0;
  int bad_stall = 0;

  always #(CLK_NS/2) clk = ~clk;

  blk_dma #(.AW(AW), .CW(CW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_addr(mem_addr),
    .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .per_rdy(per_rdy), .per_stb(per_stb),
    .per_wdata(per_wdata), .per_rdata(per_rdata)
  );

  assign mem_rdata = mem[mem_addr[3:0]];
  assign per_rdata = 32'hC0DE_0000 | DW'(src_idx);

  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr[3:0]] <= mem_wdata;
    if (per_stb) begin
      sink[stb_cnt[3:0]] <= per_wdata;
      src_idx <= src_idx + 1;
      stb_cnt <= stb_cnt + 1;
    end
    if ((mem_wr || mem_rd) && !(bus_req && bus_gnt)) bad_access <= bad_access + 1;
    if (per_stb && !(bus_gnt && per_rdy)) bad_stall <= bad_stall + 1;
  end

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] sel, input logic [DW-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] sel, output logic [DW-1:0] d);
    reg_sel = sel;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && bus_req; i++) begin
      @(negedge clk);
      per_rdy = ~per_rdy | bus_gnt;
    end
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    chk("R1 bus_req", DW'(bus_req), 0);
    chk("R1 irq", DW'(irq), 0);
    chk("R1 strobes", DW'({mem_wr, mem_rd, per_stb}), 0);
    for (int s = 0; s < 4; s++) begin
      reg_read(2'(s), v);
      chk("R1 reg readback", v, 0);
    end
  endtask

  task automatic t_p2m();
    logic [DW-1:0] v;
    int base;
    base = src_idx;
    bus_gnt = 1'b1; per_rdy = 1'b1;
    reg_write(2'd0, 32'd4);
    reg_write(2'd1, 32'd3);
    reg_read(2'd0, v); chk("R2 addr readback", v, 4);
    reg_read(2'd1, v); chk("R2 len readback", v, 3);
    reg_write(2'd2, 32'h1);
    chk("R3 request after start", DW'(bus_req), 1);
    // three words move in the three cycles after start
    @(negedge clk); @(negedge clk);
    chk("R7 still busy before last", DW'(bus_req), 1);
    chk("R7 irq low before last", DW'(irq), 0);
    @(negedge clk);
    chk("R7 request dropped", DW'(bus_req), 0);
    chk("R7 irq raised", DW'(irq), 1);
    for (int k = 0; k < 3; k++)
      chk("R4 memory word", mem[4+k], 32'hC0DE_0000 | DW'(base + k));
    reg_read(2'd3, v); chk("R2 status done idle", v, 32'h2);
  endtask

  task automatic t_irq_w1c();
    logic [DW-1:0] v;
    repeat (3) @(negedge clk);
    chk("R9 irq held", DW'(irq), 1);
    reg_write(2'd3, 32'h1);
    chk("R9 write without bit1", DW'(irq), 1);
    reg_write(2'd3, 32'h2);
    chk("R9 cleared", DW'(irq), 0);
    reg_read(2'd3, v); chk("R9 status cleared", v, 0);
  endtask

  task automatic t_m2p();
    int s0;
    logic [DW-1:0] v;
    s0 = stb_cnt;
    bus_gnt = 1'b0; per_rdy = 1'b1;
    reg_write(2'd0, 32'd4);
    reg_write(2'd1, 32'd3);
    reg_write(2'd2, 32'h3);
    reg_read(2'd2, v); chk("R2 dir readback", v, 32'h2);
    repeat (3) @(negedge clk);
    chk("R6 no word without grant", DW'(stb_cnt - s0), 0);
    chk("R6 request held", DW'(bus_req), 1);
    bus_gnt = 1'b1; per_rdy = 1'b0;
    wait_idle();
    chk("R5 word count", DW'(stb_cnt - s0), 3);
    for (int k = 0; k < 3; k++)
      chk("R5 peripheral word", sink[(s0+k) % 16], mem[4+k]);
    chk("R6 no stall violation", DW'(bad_stall), 0);
    chk("R7 irq after m2p", DW'(irq), 1);
    reg_write(2'd3, 32'h2);
  endtask

  task automatic t_zero();
    int s0;
    s0 = stb_cnt;
    reg_write(2'd1, 32'd0);
    reg_write(2'd2, 32'h1);
    chk("R8 irq at once", DW'(irq), 1);
    chk("R8 no request", DW'(bus_req), 0);
    repeat (4) begin
      @(negedge clk);
      chk("R8 request stays low", DW'(bus_req), 0);
    end
    chk("R8 no words", DW'(stb_cnt - s0), 0);
    reg_write(2'd3, 32'h2);
  endtask

  task automatic t_busy_lock();
    int s0;
    logic [DW-1:0] v;
    s0 = stb_cnt;
    bus_gnt = 1'b0; per_rdy = 1'b1;
    reg_write(2'd0, 32'd10);
    reg_write(2'd1, 32'd2);
    reg_write(2'd2, 32'h1);
    reg_write(2'd0, 32'd1);
    reg_write(2'd1, 32'd9);
    reg_write(2'd2, 32'h3);
    reg_read(2'd0, v); chk("R10 addr frozen", v, 10);
    reg_read(2'd1, v); chk("R10 len frozen", v, 2);
    reg_read(2'd2, v); chk("R10 dir frozen", v, 0);
    bus_gnt = 1'b1;
    wait_idle();
    chk("R10 original count only", DW'(stb_cnt - s0), 2);
    repeat (2) @(negedge clk);
    chk("R10 no restart", DW'(bus_req), 0);
  endtask

  task automatic t_collide();
    logic [DW-1:0] v;
    chk("R11 irq pending", DW'(irq), 1);
    bus_gnt = 1'b0; per_rdy = 1'b1;
    reg_write(2'd0, 32'd12);
    reg_write(2'd1, 32'd1);
    reg_write(2'd2, 32'h1);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = 2'd3; reg_wdata = 32'h2;
    bus_gnt = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
    chk("R11 completion wins", DW'(irq), 1);
    reg_read(2'd3, v); chk("R11 status", v, 32'h2);
    reg_write(2'd3, 32'h2);
    chk("R11 later clear", DW'(irq), 0);
  endtask

  initial begin
    #(CLK_NS * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '0;
    rst_n = 1'b0; reg_we = 1'b0; reg_sel = '0; reg_wdata = '0;
    bus_gnt = 1'b0; per_rdy = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_p2m();
    t_irq_w1c();
    t_m2p();
    t_zero();
    t_busy_lock();
    reg_write(2'd3, 32'h0);
    t_collide();
    chk("R3 grant before access", DW'(bad_access), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule